// File: doc/BRIEF.md
# Dual-Resolution Motor PWM Timer

This block is a timer and PWM generator for motor outputs. A free-running timer counter, clocked by a divided version of the bus clock, sets the PWM period. Each channel compares the counter against its own duty value and drives its output high while the counter is below that value. One control register selects the clock divide, the counter resolution, dither enable and how the block acts in wait mode. It also holds a sticky overflow flag.

Software reaches the block through a single-cycle register bus. Writes take effect at the clock edge and reads are combinational. Address 0 is the control register. Addresses 1 to NUM_CH are the channel duty registers, where address 1 is channel 0. The resolution mode sets the counter length and also sets how wide the duty registers are on the bus. A new clock divide is held back until the next period starts, so a period never mixes two divide rates.

Top module: `motor_pwm_timer`

## Requirements
- R1: The control register at address 0 holds the prescaler code in bits 6:5, stop-in-wait in bit 4, fast mode in bit 3, dither enable in bit 2 and the overflow flag in bit 0. Bits 7, 1 and 15:8 read as 0, and every field is 0 after reset.
- R2: Prescaler codes 0, 1, 2 and 3 divide the bus clock by 1, 2, 4 and 8, so each counter value lasts that many cycles.
- R3: A new prescaler code is applied only at the next counter wrap. Until then the old divide stays in force.
- R4: With fast mode clear, the counter runs from 0 to 2047 and then wraps. A duty write stores data bits 10:0, and a duty read returns those 11 bits with the upper bits 0.
- R5: With fast mode set, the counter runs from 0 to 127 and then wraps. A duty write stores only data bits 7:0, and a duty read returns the low 8 bits with the upper bits 0.
- R6: A channel output is high while the counter is below the channel's duty value. A duty of 0 gives a constant low, so the output is high for duty × divide cycles in each period.
- R7: Each counter wrap sets the overflow flag. The flag stays set when 0 is written to bit 0 and is cleared by writing 1 to bit 0. A wrap in the same cycle as the clear wins.
- R8: While stop-in-wait is 1 and wait_i is high, the counter and the divider freeze and pwm_oe_o and pwm_o go low. While stop-in-wait is 0, wait_i has no effect.
- R9: Addresses above NUM_CH are reserved. Writes to them change no state, and reads from them return 0.
- R10: dith_en_o follows the dither enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | Wait-mode request |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| dith_en_o | output | 1 | Dither enable to the dither path |
| tmr_cnt_o | output | CNT_W | Timer counter value |
| pwm_o | output | NUM_CH | Channel PWM outputs |
| pwm_oe_o | output | 1 | Output enable; low when the pins are released |

## Verification
Assertions check several properties on every cycle. A wrap returns the counter to 0, the active divide changes only at a wrap and a wrap always sets the flag. The counter does not move while wait mode is stopping the block. A duty of 0 never drives a high output, and a reserved address always reads 0. The bench scenarios cover what needs a whole period to show: period lengths for each divide code and resolution, high time as a function of duty and the byte truncation of duty writes. They also cover the deferral of a divide change to the next period and the write-1-to-clear sequence of the flag.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int PRESC_LSB = 5;
  localparam int SWAI_BIT  = 4;
  localparam int FAST_BIT  = 3;
  localparam int DITH_BIT  = 2;
  localparam int OVF_BIT   = 0;

  typedef struct packed {
    logic [1:0] presc;
    logic       swai;
    logic       fast;
    logic       dith;
    logic       ovf;
  } ctl_t;
endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             period_start_i,
  input  logic [PRE_W-1:0] presc_req_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [PRE_W-1:0] presc_act_q;
  logic [DIV_W-1:0] div_q, lim;

  // terminal count = 2^code - 1
  always_comb begin
    lim = '0;
    for (int i = 0; i < DIV_W; i++) lim[i] = (i < int'(presc_act_q));
  end

  assign tick_o = run_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= '0;
      presc_act_q <= '0;
    end else if (run_i) begin
      div_q <= tick_o ? '0 : div_q + 1'b1;
      if (period_start_i) presc_act_q <= presc_req_i;
    end
  end

  p_presc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(presc_act_q));
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int CNT_W  = 11,
  parameter int FAST_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fast_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] MAX_NORM = '1;
  localparam logic [CNT_W-1:0] MAX_FAST = CNT_W'((1 << FAST_W) - 1);

  logic [CNT_W-1:0] top_val;
  assign top_val = fast_i ? MAX_FAST : MAX_NORM;
  // >= covers a switch to fast while above the short terminal
  assign wrap_o  = tick_i && (cnt_o >= top_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
  parameter int CNT_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fast_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_eff;
  assign duty_eff = fast_i ? CNT_W'(duty_i[BYTE_W-1:0]) : duty_i;
  assign pwm_o    = cnt_i < duty_eff;
endmodule

// File: rtl/motor_pwm_timer.sv
module motor_pwm_timer
  import mtmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 11,
  parameter int FAST_W = 7,
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dith_en_o,
  output logic [CNT_W-1:0]  tmr_cnt_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              pwm_oe_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] duty_q [NUM_CH];
  logic             run, tick, wrap, wr_ctl, rsv_hit;
  logic [NUM_CH-1:0] ch_pwm;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];
  assign run      = !(ctl_q.swai && wait_i);
  assign wr_ctl   = wr_en_i && (addr_i == '0);
  assign rsv_hit  = addr_i > ADDR_W'(NUM_CH);
  assign dith_en_o = ctl_q.dith;
  assign pwm_oe_o = run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.presc <= wdata_i[PRESC_LSB +: PRE_W];
        ctl_q.swai  <= wdata_i[SWAI_BIT];
        ctl_q.fast  <= wdata_i[FAST_BIT];
        ctl_q.dith  <= wdata_i[DITH_BIT];
      end
      // set has priority over write-1-to-clear
      ctl_q.ovf <= wrap || (ctl_q.ovf && !(wr_ctl && wdata_i[OVF_BIT]));
    end
  end

  mtmr_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk_i, .rst_ni,
    .run_i          (run),
    .period_start_i (wrap),
    .presc_req_i    (ctl_q.presc),
    .tick_o         (tick)
  );

  mtmr_counter #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .fast_i (ctl_q.fast),
    .cnt_o  (tmr_cnt_o),
    .wrap_o (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_duty;
    assign wr_duty = wr_en_i && (addr_i == ADDR_W'(c + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      duty_q[c] <= '0;
      else if (wr_duty) duty_q[c] <= ctl_q.fast ? CNT_W'(wdata_i[BYTE_W-1:0])
                                                : wdata_i[CNT_W-1:0];
    end

    mtmr_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
      .cnt_i  (tmr_cnt_o),
      .fast_i (ctl_q.fast),
      .duty_i (duty_q[c]),
      .pwm_o  (ch_pwm[c])
    );

    p_duty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_q[c] == '0) |-> !pwm_o[c]);
  end

  assign pwm_o = run ? ch_pwm : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[PRESC_LSB +: PRE_W] = ctl_q.presc;
      rdata_o[SWAI_BIT] = ctl_q.swai;
      rdata_o[FAST_BIT] = ctl_q.fast;
      rdata_o[DITH_BIT] = ctl_q.dith;
      rdata_o[OVF_BIT]  = ctl_q.ovf;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (addr_i == ADDR_W'(c + 1))
          rdata_o = ctl_q.fast ? DATA_W'(duty_q[c][BYTE_W-1:0]) : DATA_W'(duty_q[c]);
    end
  end

  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ctl_q.ovf);
  p_wait_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.swai && wait_i) |=> $stable(tmr_cnt_o));
  p_rsv_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_hit |-> (rdata_o == '0));
endmodule

// File: tb/motor_pwm_timer_tb_top.sv
module motor_pwm_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wait_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        dith_en_o;
  logic [10:0] tmr_cnt_o;
  logic [3:0]  pwm_o;
  logic        pwm_oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  motor_pwm_timer dut_i (.*);

  typedef struct packed {
    logic        fast;
    logic [1:0]  presc;
    logic [15:0] duty;
    logic [31:0] period;
    logic [31:0] high;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 16'd0,    32'd128,  32'd0},
    '{1'b1, 2'd0, 16'd40,   32'd128,  32'd40},
    '{1'b1, 2'd1, 16'd100,  32'd256,  32'd200},
    '{1'b1, 2'd3, 16'd300,  32'd1024, 32'd352},
    '{1'b1, 2'd0, 16'd127,  32'd128,  32'd127},
    '{1'b0, 2'd0, 16'd2047, 32'd2048, 32'd2047},
    '{1'b0, 2'd2, 16'd5,    32'd8192, 32'd20},
    '{1'b0, 2'd0, 16'd1000, 32'd2048, 32'd1000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  // ends at the first negedge of a fresh period
  task automatic sync_start();
    do @(negedge clk_i); while (tmr_cnt_o == 0);
    do @(negedge clk_i); while (tmr_cnt_o != 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [10:0] a, b, prev;
    int per, hi;
    repeat (3) @(negedge clk_i);
    check("R1 reset count", tmr_cnt_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(0, d);
    check("R1 reset ctl", d, 0);
    check("R1 reset oe", pwm_oe_o, 1);
    check("R6 reset pwm", pwm_o, 0);

    // period and high time per table row: R2 R4 R5 R6
    foreach (VECS[i]) begin
      wr(0, 16'({VECS[i].presc, 5'b0} | {VECS[i].fast, 3'b0}));
      wr(1, VECS[i].duty);
      sync_start();
      per = 0; hi = 0;
      do begin
        if (pwm_o[0]) hi++;
        per++;
        prev = tmr_cnt_o;
        @(negedge clk_i);
      end while (!(tmr_cnt_o == 0 && prev != 0));
      check($sformatf("R2 R4 R5 period row %0d", i), per, VECS[i].period);
      check($sformatf("R6 high row %0d", i), hi, VECS[i].high);
      if (i == 3) begin
        rd(1, d);
        check("R5 byte duty read", d, 44);
      end
    end

    // duty access width
    wr(0, 16'h0000);
    wr(2, 16'hFFFF);
    rd(2, d);
    check("R4 word duty read", d, 16'h07FF);
    wr(0, 16'h0008);
    wr(2, 16'hFFFF);
    rd(2, d);
    check("R5 byte duty read", d, 16'h00FF);

    // deferred prescaler
    sync_start();
    wr(0, 16'h0068);
    a = tmr_cnt_o;
    @(negedge clk_i);
    b = tmr_cnt_o;
    check("R3 old divide kept", 32'(b), 32'(a) + 1);
    sync_start();
    per = 0;
    while (tmr_cnt_o == 0) begin per++; @(negedge clk_i); end
    check("R3 new divide at wrap", per, 8);

    // overflow flag
    wr(0, 16'h0008);
    sync_start();
    rd(0, d);
    check("R7 flag set", d[0], 1);
    wr(0, 16'h0009);
    rd(0, d);
    check("R7 flag cleared", d[0], 0);
    sync_start();
    wr(0, 16'h0008);
    rd(0, d);
    check("R7 write 0 keeps flag", d[0], 1);

    // wait mode
    wr(1, 16'd127);
    wr(0, 16'h0018);
    @(negedge clk_i);
    wait_i = 1'b1;
    #0.5;
    check("R8 oe released", pwm_oe_o, 0);
    check("R8 pwm low", pwm_o, 0);
    a = tmr_cnt_o;
    repeat (20) @(negedge clk_i);
    check("R8 counter frozen", tmr_cnt_o, a);
    wait_i = 1'b0;
    wr(0, 16'h0008);
    wait_i = 1'b1;
    a = tmr_cnt_o;
    @(negedge clk_i);
    check("R8 no effect when clear", tmr_cnt_o == a, 0);
    check("R8 oe kept", pwm_oe_o, 1);
    wait_i = 1'b0;

    // layout and dither
    wr(0, 16'hFFFF);
    rd(0, d);
    check("R1 field layout", d & 16'hFFFE, 16'h007C);
    check("R10 dither out", dith_en_o, 1);
    wr(0, 16'h0001);
    check("R10 dither off", dith_en_o, 0);

    // reserved address
    wr(1, 16'h0055);
    wr(9, 16'hFFFF);
    rd(9, d);
    check("R9 reserved read", d, 0);
    rd(1, d);
    check("R9 duty untouched", d, 16'h0055);
    rd(0, d);
    check("R9 ctl untouched", d & 16'hFFFE, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule